// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block is the master side of a link to a two-channel serial converter. That converter has no frame-long chip select. A short conversion-start strobe begins each acquisition, and the converter then needs a fixed run of serial clocks to shift out both results. The block derives that serial clock from the system clock through a programmable divider. It raises the strobe for one serial period, with the serial clock held low, and then issues exactly 34 serial clock cycles. In those cycles it collects two 14-bit words, most significant bit first. Channel 0 comes first, and both words sit between two-cycle high-impedance gaps.

The converter returns in each frame the sample it took at the previous strobe. The block therefore drops the first frame after reset. At the end of every later frame it updates both channel registers together and raises a one-cycle valid pulse. A single-cycle start request launches one frame. A free-run level launches frames back to back, separated by two idle system cycles.

Top module: `adc_pair_capture`

## Requirements
- R1: While reset is asserted and after its release, conv_o, sck_o and valid_o are low and both channel outputs read zero until the first valid pulse.
- R2: Each frame opens with conv_o high for exactly 2*(div_i+1) system cycles, and sck_o stays low for as long as conv_o is high.
- R3: After each conversion strobe, sck_o makes exactly 34 rising edges before the next strobe or the return to idle.
- R4: Each high phase of sck_o lasts div_i+1 system cycles. When no frame is running, sck_o and conv_o stay low.
- R5: miso_i is sampled when sck_o rises. Rising edges are counted from 1 after the strobe. Edges 3 to 16 load ch0_o from bit 13 down to bit 0, and edges 19 to 34 minus 2 (19 to 32) load ch1_o in the same order. The value on miso_i at edges 1, 2, 17, 18, 33 and 34 has no effect on either output.
- R6: Both channel outputs change only in the system cycle in which valid_o is high. valid_o is one cycle wide and follows the 34th serial cycle of a frame.
- R7: The first frame after reset produces no valid pulse and leaves the channel outputs unchanged.
- R8: A one-cycle start_i pulse while idle launches exactly one frame. free_run_i held high runs frames back to back. With both low, no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request for one acquisition frame |
| free_run_i | input | 1 | Repeat frames continuously while high |
| div_i | input | 8 | Serial clock half-period minus one, in system cycles |
| miso_i | input | 1 | Serial data from the converter |
| conv_o | output | 1 | Conversion-start strobe |
| sck_o | output | 1 | Gated serial clock |
| ch0_o | output | 14 | Latest channel 0 result |
| ch1_o | output | 14 | Latest channel 1 result |
| valid_o | output | 1 | One-cycle pulse when both results update |

## Verification
The hardest case to reach is bits landing in the wrong slot: a word shifted by one serial cycle, or gap-cycle values leaking into a result. The bench converter model drives a logic one during every gap cycle. The data patterns include all-ones, all-zeros and words with isolated end bits, and they are run at several divider settings, so any off-by-one in slot decoding corrupts a compared word. The one-frame latency is modelled so that the dropped first frame and every later pairing of strobe and result are checked against a queue.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/adc_sck_tick.sv
module adc_sck_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == div_i);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: the half-period counter never passes the programmed limit
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= div_i));

    // R4: ticks are spaced by div_i+1 cycles, never back to back unless div_i is zero
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/adc_slot_decode.sv
module adc_slot_decode #(
    parameter int DATA_W  = 14,
    parameter int GAP_CYC = 2,
    parameter int BIT_W   = 6
) (
    input  logic [BIT_W-1:0] bit_idx_i,
    output logic [1:0]       en_o
);
    localparam logic [BIT_W-1:0] C0_LO = BIT_W'(GAP_CYC);
    localparam logic [BIT_W-1:0] C0_HI = BIT_W'(GAP_CYC + DATA_W - 1);
    localparam logic [BIT_W-1:0] C1_LO = BIT_W'(2 * GAP_CYC + DATA_W);
    localparam logic [BIT_W-1:0] C1_HI = BIT_W'(2 * GAP_CYC + 2 * DATA_W - 1);

    always_comb begin
        en_o[0] = (bit_idx_i >= C0_LO) && (bit_idx_i <= C0_HI);
        en_o[1] = (bit_idx_i >= C1_LO) && (bit_idx_i <= C1_HI);
    end
endmodule

// File: rtl/adc_word_shift.sv
module adc_word_shift #(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_i) word_d = {word_q[DATA_W-2:0], bit_i};
        word_o = word_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end
endmodule

// File: rtl/adc_pair_capture.sv
module adc_pair_capture
    import adc_cap_pkg::*;
#(
    parameter int DATA_W  = 14,
    parameter int GAP_CYC = 2,
    parameter int DIV_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              free_run_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              miso_i,
    output logic              conv_o,
    output logic              sck_o,
    output logic [DATA_W-1:0] ch0_o,
    output logic [DATA_W-1:0] ch1_o,
    output logic              valid_o
);
    localparam int N_CH  = 2;
    localparam int FRAME = 3 * GAP_CYC + 2 * DATA_W;
    localparam int BIT_W = $clog2(FRAME);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME - 1);

    typedef struct packed {
        seq_state_e        st;
        logic              phase;
        logic              sck;
        logic [BIT_W-1:0]  bit_idx;
        logic              pend;
        logic              primed;
        logic              valid;
        logic [DATA_W-1:0] ch0;
        logic [DATA_W-1:0] ch1;
    } seq_t;

    seq_t              seq_d, seq_q;
    logic              run, tick, sample;
    logic [N_CH-1:0]   slot_en;
    logic [DATA_W-1:0] word [N_CH];

    assign run    = (seq_q.st == ST_CONV) || (seq_q.st == ST_SHIFT);
    assign sample = tick && (seq_q.st == ST_SHIFT) && !seq_q.sck;

    adc_sck_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    adc_slot_decode #(.DATA_W(DATA_W), .GAP_CYC(GAP_CYC), .BIT_W(BIT_W)) u_dec (
        .bit_idx_i (seq_q.bit_idx),
        .en_o      (slot_en)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        adc_word_shift #(.DATA_W(DATA_W)) u_shift (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_i (sample && slot_en[c]),
            .bit_i   (miso_i),
            .word_o  (word[c])
        );
    end

    always_comb begin
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        if (start_i && seq_q.st != ST_IDLE) seq_d.pend = 1'b1;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i || seq_q.pend || free_run_i) begin
                    seq_d.st    = ST_CONV;
                    seq_d.phase = 1'b0;
                    seq_d.pend  = 1'b0;
                end
            end
            ST_CONV: begin
                if (tick) begin
                    if (seq_q.phase) begin
                        seq_d.st      = ST_SHIFT;
                        seq_d.bit_idx = '0;
                        seq_d.sck     = 1'b0;
                    end else begin
                        seq_d.phase = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!seq_q.sck) begin
                        seq_d.sck = 1'b1;
                    end else begin
                        seq_d.sck = 1'b0;
                        if (seq_q.bit_idx == LAST_BIT) seq_d.st = ST_DONE;
                        else seq_d.bit_idx = seq_q.bit_idx + 1'b1;
                    end
                end
            end
            default: begin
                seq_d.valid  = seq_q.primed;
                if (seq_q.primed) begin
                    seq_d.ch0 = word[0];
                    seq_d.ch1 = word[1];
                end
                seq_d.primed = 1'b1;
                seq_d.st     = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign conv_o  = (seq_q.st == ST_CONV);
    assign sck_o   = seq_q.sck;
    assign ch0_o   = seq_q.ch0;
    assign ch1_o   = seq_q.ch1;
    assign valid_o = seq_q.valid;

    // R2: no serial clock activity while the strobe is high
    p_conv_no_sck_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_o |-> !sck_o);

    // R3: the bit index stays inside the 34-cycle frame
    p_bit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.bit_idx <= LAST_BIT);

    // R4: idle means both serial outputs are quiet
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> (!sck_o && !conv_o));

    // R5: the two channel slots never overlap
    p_slot_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot_en[0] && slot_en[1]));

    // R6: valid lasts a single cycle
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: results move only together with valid
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(ch0_o) && $stable(ch1_o)));

    // R7: a valid pulse needs an earlier completed frame
    p_first_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(seq_q.primed));
endmodule

// File: tb/sim_adc_pair_capture.sv
module sim_adc_pair_capture;
    localparam int DATA_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              free_run_i = 1'b0;
    logic [7:0]        div_i = 8'd0;
    logic              miso_i;
    logic              conv_o, sck_o, valid_o;
    logic [DATA_W-1:0] ch0_o, ch1_o;

    adc_pair_capture u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .free_run_i(free_run_i),
        .div_i(div_i), .miso_i(miso_i), .conv_o(conv_o), .sck_o(sck_o),
        .ch0_o(ch0_o), .ch1_o(ch1_o), .valid_o(valid_o)
    );

    always #4 clk = ~clk;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // converter model: returns at each frame the sample taken at the previous strobe
    logic [DATA_W-1:0] out0 = 14'h1555, out1 = 14'h2AAA;
    logic [DATA_W-1:0] smp0 = '0, smp1 = '0;
    bit                have_smp = 1'b0;
    int                fcnt = 0;
    int                pat_i = 0;
    logic [DATA_W-1:0] exp0_q[$];
    logic [DATA_W-1:0] exp1_q[$];

    task automatic next_pat(output logic [DATA_W-1:0] a, output logic [DATA_W-1:0] b);
        case (pat_i)
            0: begin a = 14'h3FFF; b = 14'h0000; end
            1: begin a = 14'h0000; b = 14'h3FFF; end
            2: begin a = 14'h2001; b = 14'h2001; end
            3: begin a = 14'h2AAA; b = 14'h1555; end
            default: begin a = DATA_W'($urandom); b = DATA_W'($urandom); end
        endcase
        pat_i++;
    endtask

    // driver side of the scoreboard: each strobe pushes the expected pair for this frame
    always @(posedge conv_o) begin
        if (have_smp) begin
            exp0_q.push_back(smp0);
            exp1_q.push_back(smp1);
            out0 = smp0;
            out1 = smp1;
        end
        next_pat(smp0, smp1);
        have_smp = 1'b1;
        fcnt = 0;
    end

    always @(negedge sck_o) fcnt++;

    always @* begin
        if (fcnt >= 2 && fcnt <= 15)       miso_i = out0[15 - fcnt];
        else if (fcnt >= 18 && fcnt <= 31) miso_i = out1[31 - fcnt];
        else                               miso_i = 1'b1;
    end

    // monitor
    int conv_len = 0, hi_len = 0, rises = 0, conv_rises = 0, valid_cnt = 0;
    bit prev_conv = 0, prev_sck = 0, prev_valid = 0, frame_on = 0;
    logic [DATA_W-1:0] e0, e1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_o) begin
                conv_len++;
                if (sck_o) check(1'b0, "R2 sck during strobe", 1, 0);
            end
            if (prev_conv && !conv_o) begin
                check(conv_len == 2 * (int'(div_i) + 1), "R2 strobe width", conv_len, 2 * (int'(div_i) + 1));
                conv_len = 0;
            end
            if (!prev_conv && conv_o) begin
                if (frame_on) check(rises == 34, "R3 edges per frame", rises, 34);
                rises = 0;
                frame_on = 1;
                conv_rises++;
            end
            if (sck_o) hi_len++;
            if (!prev_sck && sck_o) rises++;
            if (prev_sck && !sck_o) begin
                check(hi_len == int'(div_i) + 1, "R4 sck high time", hi_len, int'(div_i) + 1);
                hi_len = 0;
            end
            if (valid_o) begin
                valid_cnt++;
                check(!prev_valid, "R6 valid width", 1, 0);
                check(rises == 34, "R6 valid after frame end", rises, 34);
                if (exp0_q.size() == 0) begin
                    check(1'b0, "R7 unexpected valid", 1, 0);
                end else begin
                    e0 = exp0_q.pop_front();
                    e1 = exp1_q.pop_front();
                    check(ch0_o == e0, "R5 ch0 word", ch0_o, e0);
                    check(ch1_o == e1, "R5 ch1 word", ch1_o, e1);
                end
            end
            prev_conv = conv_o;
            prev_sck = sck_o;
            prev_valid = valid_o;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_frame(input int d);
        repeat (72 * (d + 1) + 10) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int held;
        repeat (4) @(negedge clk);
        check(!conv_o && !sck_o && !valid_o, "R1 outputs low in reset", {conv_o, sck_o, valid_o}, 0);
        check(ch0_o == 0 && ch1_o == 0, "R1 words zero in reset", {ch0_o, ch1_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(conv_rises == 0 && !sck_o, "R8 R4 idle without request", conv_rises, 0);
        check(ch0_o == 0 && ch1_o == 0, "R1 words zero after reset", {ch0_o, ch1_o}, 0);

        div_i = 8'd0;
        pulse_start();
        wait_frame(0);
        check(conv_rises == 1, "R8 single frame per start", conv_rises, 1);
        check(valid_cnt == 0, "R7 first frame dropped", valid_cnt, 0);
        check(ch0_o == 0 && ch1_o == 0, "R7 words unchanged", {ch0_o, ch1_o}, 0);

        pulse_start();
        wait_frame(0);
        check(valid_cnt == 1, "R6 valid after second frame", valid_cnt, 1);

        div_i = 8'd2;
        pulse_start();
        wait_frame(2);
        check(conv_rises == 3 && valid_cnt == 2, "R8 third start", conv_rises, 3);

        div_i = 8'd3;
        @(negedge clk) free_run_i = 1'b1;
        while (conv_rises < 7) @(negedge clk);
        free_run_i = 1'b0;
        wait_frame(3);
        wait_frame(3);
        check(conv_rises == 7, "R8 free run stops", conv_rises, 7);
        check(valid_cnt == conv_rises - 1, "R6 one valid per later frame", valid_cnt, conv_rises - 1);
        check(rises == 34, "R3 last frame edges", rises, 34);
        check(exp0_q.size() == 0, "R5 scoreboard drained", exp0_q.size(), 0);

        held = conv_rises;
        repeat (300) @(negedge clk);
        check(conv_rises == held && !sck_o && !conv_o, "R4 R8 quiet after stop", conv_rises, held);
        finish_run();
    end
endmodule